// File: doc/BRIEF.md
# SD Host Block-Gap Transfer Tracker

This block follows the data phase of an SD host controller and reports whether a read or a write transfer currently occupies the DAT lines. The command engine and the data engine send it single-cycle event pulses. These are: the end bit of a data command has been sent, the end bit of a read block has arrived, and the CRC status token of a written block has arrived. It also sees a level that says the read buffer is full. The engine supplies the number of blocks still to move, counting the block in flight. Two register write strobes carry the software requests: one asks the transfer to stop at a block gap and one asks it to continue.

The tracker keeps two status flags, write-active and DAT-line-active. It drives the read-wait request toward the data engine and raises two one-cycle interrupt pulses. The block-gap event pulse marks a transfer that was paused by a stop request. The transfer-complete pulse marks a transfer that ended on its last block. A paused read holds read-wait until the continue strobe releases it. A paused write just stops before its next block.

There is no data stream through this block. Every pin is a plain control or status signal, so it has no valid/ready handshake and no back-pressure. The buffer-full level is the only flow-control input, and it acts through read-wait.

Top module: `sd_gap_tracker`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `wr_active`, `dat_active`, `read_wait`, `gap_evt` and `xfer_done`, and it also drops any pending stop or pause.
- R2: While idle, a `cmd_end` pulse with `is_write`=1 sets both `wr_active` and `dat_active` one cycle later. With `is_write`=0 it sets only `dat_active`.
- R3: A block gap is a `crc_stat` pulse for a write or a `blk_end` pulse for a read. A block gap with `blk_left`=1 ends the transfer: the flags drop and `xfer_done` pulses in the next cycle, `gap_evt` stays low, and this holds even when a stop is pending.
- R4: After a stop request during a write, the next `crc_stat` with `blk_left`>1 clears `wr_active` and `dat_active` and pulses `gap_evt` in the next cycle.
- R5: After a stop request during a read, the next `blk_end` with `blk_left`>1 clears `dat_active`, raises `read_wait` and pulses `gap_evt` in the next cycle.
- R6: During a read with `buf_full` high, `read_wait` is already driven. A stop request then pauses the read right away, without waiting for another block: `gap_evt` pulses and `dat_active` falls in the next cycle, and `read_wait` stays high after `buf_full` falls.
- R7: A `stop_req` strobe in the same cycle as a block gap takes effect at that gap.
- R8: A `cont_req` strobe while paused restores the flags of the paused direction in the next cycle. It releases `read_wait` and clears the stop, so the next gap does not pause.
- R9: `cont_req` is ignored when no transfer is paused, and `stop_req` is ignored when no transfer is active.
- R10: During an active read, `read_wait` follows `buf_full` in the same cycle. Without a stop request this never pauses the transfer.
- R11: `gap_evt` and `xfer_done` are high for exactly one cycle and never high together.
- R12: `cmd_end` is ignored while a transfer is active or paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_end | input | 1 | Pulse: end bit of a data command sent |
| is_write | input | 1 | Direction of the command in `cmd_end` (1 = write) |
| blk_end | input | 1 | Pulse: end bit of a read block received |
| crc_stat | input | 1 | Pulse: CRC status of a written block received |
| buf_full | input | 1 | Level: read buffer cannot take another block |
| blk_left | input | CNT_W | Blocks still to move, including the one in flight |
| stop_req | input | 1 | Strobe: software asks to stop at a block gap |
| cont_req | input | 1 | Strobe: software asks to continue a paused transfer |
| wr_active | output | 1 | Write transfer holds valid data |
| dat_active | output | 1 | A DAT line is in use by the transfer |
| read_wait | output | 1 | Request to the data engine to hold read-wait |
| gap_evt | output | 1 | One-cycle pulse: transfer paused at a block gap |
| xfer_done | output | 1 | One-cycle pulse: transfer finished its last block |

## Verification
Two functions can land in the same cycle: a stop strobe can coincide with a block gap, and a gap can be the final block while a stop is pending. The sweep covers both directions, transfer lengths of one to four blocks and every stop position. It places the stop strobe either one cycle ahead of the gap or in the gap cycle itself. In the coincident case the bench expects the pause at that same gap. When the stop meets the final block, it expects the transfer-complete pulse alone, with no block-gap event and no read-wait.

// File: rtl/sdgt_pkg.sv
package sdgt_pkg;
  typedef enum logic {DIR_RD = 1'b0, DIR_WR = 1'b1} xfer_dir_e;

  typedef struct packed {
    logic gap_hit;  // a block boundary of the running transfer
    logic finish;   // boundary of the final block
    logic pause;    // stop honoured at this cycle
  } gap_act_t;
endpackage

// File: rtl/sdgt_gap_decode.sv
module sdgt_gap_decode
  import sdgt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  xfer_dir_e        dir,
  input  logic             wr_act,
  input  logic             dat_act,
  input  logic             blk_end,
  input  logic             crc_stat,
  input  logic             buf_full,
  input  logic             stop_eff,
  input  logic [CNT_W-1:0] blk_left,
  output gap_act_t         act
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

  logic is_last, rd_held;

  always_comb begin
    is_last     = (blk_left == LAST);
    act.gap_hit = (dir == DIR_WR) ? (wr_act & crc_stat) : (dat_act & blk_end);
    // a read already held by a full buffer sits at a gap now
    rd_held     = (dir == DIR_RD) & dat_act & buf_full & ~act.gap_hit;
    act.finish  = act.gap_hit & is_last;
    act.pause   = stop_eff & ((act.gap_hit & ~is_last) | rd_held);
  end
endmodule

// File: rtl/sdgt_state.sv
module sdgt_state
  import sdgt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cmd_end,
  input  logic      is_write,
  input  logic      cont_req,
  input  logic      stop_req,
  input  gap_act_t  act,
  output xfer_dir_e dir,
  output logic      wr_active,
  output logic      dat_active,
  output logic      stop_pend,
  output logic      rw_hold,
  output logic      gap_evt,
  output logic      xfer_done
);
  logic paused;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir        <= DIR_RD;
      wr_active  <= 1'b0;
      dat_active <= 1'b0;
      stop_pend  <= 1'b0;
      rw_hold    <= 1'b0;
      paused     <= 1'b0;
      gap_evt    <= 1'b0;
      xfer_done  <= 1'b0;
    end else begin
      gap_evt   <= act.pause;
      xfer_done <= act.finish;
      if (cmd_end && !dat_active && !paused) begin
        dir        <= is_write ? DIR_WR : DIR_RD;
        dat_active <= 1'b1;
        wr_active  <= is_write;
        stop_pend  <= 1'b0;
      end else if (act.finish) begin
        dat_active <= 1'b0;
        wr_active  <= 1'b0;
        stop_pend  <= 1'b0;
      end else if (act.pause) begin
        dat_active <= 1'b0;
        wr_active  <= 1'b0;
        stop_pend  <= 1'b0;
        paused     <= 1'b1;
        rw_hold    <= (dir == DIR_RD);
      end else if (cont_req && paused) begin
        paused     <= 1'b0;
        rw_hold    <= 1'b0;
        dat_active <= 1'b1;
        wr_active  <= (dir == DIR_WR);
      end else if (stop_req && dat_active) begin
        stop_pend  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sd_gap_tracker.sv
module sd_gap_tracker
  import sdgt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_end,
  input  logic             is_write,
  input  logic             blk_end,
  input  logic             crc_stat,
  input  logic             buf_full,
  input  logic [CNT_W-1:0] blk_left,
  input  logic             stop_req,
  input  logic             cont_req,
  output logic             wr_active,
  output logic             dat_active,
  output logic             read_wait,
  output logic             gap_evt,
  output logic             xfer_done
);
  xfer_dir_e dir;
  gap_act_t  act;
  logic      stop_pend, rw_hold, stop_eff;

  // a strobe arriving in the gap cycle counts at that gap
  assign stop_eff = stop_pend | (stop_req & dat_active);

  sdgt_gap_decode #(.CNT_W(CNT_W)) dec_i (
    .dir      (dir),
    .wr_act   (wr_active),
    .dat_act  (dat_active),
    .blk_end  (blk_end),
    .crc_stat (crc_stat),
    .buf_full (buf_full),
    .stop_eff (stop_eff),
    .blk_left (blk_left),
    .act      (act)
  );

  sdgt_state st_i (
    .clk        (clk),
    .rst        (rst),
    .cmd_end    (cmd_end),
    .is_write   (is_write),
    .cont_req   (cont_req),
    .stop_req   (stop_req),
    .act        (act),
    .dir        (dir),
    .wr_active  (wr_active),
    .dat_active (dat_active),
    .stop_pend  (stop_pend),
    .rw_hold    (rw_hold),
    .gap_evt    (gap_evt),
    .xfer_done  (xfer_done)
  );

  assign read_wait = rw_hold | ((dir == DIR_RD) & dat_active & buf_full);
endmodule

// File: rtl/sdgt_checker.sv
module sdgt_checker (
  input logic clk,
  input logic rst,
  input logic cmd_end,
  input logic cont_req,
  input logic wr_active,
  input logic dat_active,
  input logic read_wait,
  input logic gap_evt,
  input logic xfer_done
);
  assert_pulses_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    !(gap_evt && xfer_done));

  assert_gap_single_R11: assert property (@(posedge clk) disable iff (rst)
    gap_evt |=> !gap_evt);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> !xfer_done);

  assert_write_inside_dat_R2: assert property (@(posedge clk) disable iff (rst)
    wr_active |-> dat_active);

  assert_fall_reported_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(dat_active) |-> (gap_evt || xfer_done));

  assert_done_clears_R3: assert property (@(posedge clk) disable iff (rst)
    xfer_done |-> (!dat_active && !read_wait));

  assert_read_pause_waits_R5: assert property (@(posedge clk) disable iff (rst)
    (gap_evt && !$past(wr_active)) |-> read_wait);

  assert_rise_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(dat_active) |-> ($past(cmd_end) || $past(cont_req)));
endmodule

bind sd_gap_tracker sdgt_checker chk_i (
  .clk        (clk),
  .rst        (rst),
  .cmd_end    (cmd_end),
  .cont_req   (cont_req),
  .wr_active  (wr_active),
  .dat_active (dat_active),
  .read_wait  (read_wait),
  .gap_evt    (gap_evt),
  .xfer_done  (xfer_done)
);

// File: tb/sd_gap_tracker_tb_top.sv
`timescale 1ns/1ps
module sd_gap_tracker_tb_top;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_end = 0, is_write = 0, blk_end = 0, crc_stat = 0, buf_full = 0;
  logic stop_req = 0, cont_req = 0;
  logic [CNT_W-1:0] blk_left = '0;
  logic wr_active, dat_active, read_wait, gap_evt, xfer_done;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sd_gap_tracker #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .cmd_end(cmd_end), .is_write(is_write),
    .blk_end(blk_end), .crc_stat(crc_stat), .buf_full(buf_full),
    .blk_left(blk_left), .stop_req(stop_req), .cont_req(cont_req),
    .wr_active(wr_active), .dat_active(dat_active), .read_wait(read_wait),
    .gap_evt(gap_evt), .xfer_done(xfer_done)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_all(input string tag, input logic wr, input logic dat,
                         input logic rw, input logic ge, input logic xd);
    chk({tag, " wr_active"}, wr_active, wr);
    chk({tag, " dat_active"}, dat_active, dat);
    chk({tag, " read_wait"}, read_wait, rw);
    chk({tag, " gap_evt"}, gap_evt, ge);
    chk({tag, " xfer_done"}, xfer_done, xd);
  endtask

  // strobes set at a falling edge, cleared one full cycle later
  task automatic step();
    @(negedge clk);
    cmd_end = 0; blk_end = 0; crc_stat = 0; stop_req = 0; cont_req = 0;
  endtask

  task automatic gap(input logic wr, input int left, input logic with_stop);
    blk_left = CNT_W'(left);
    if (wr) crc_stat = 1; else blk_end = 1;
    stop_req = with_stop;
    step();
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 0;
    chk_all("R1 after reset", 0, 0, 0, 0, 0);

    // sweep: direction x length x stop position (0 = none)
    for (int d = 0; d < 2; d++) begin
      for (int n = 1; n <= 4; n++) begin
        for (int s = 0; s <= n; s++) begin
          is_write = d[0]; cmd_end = 1; step();
          chk("R2 wr_active after cmd", wr_active, d[0]);
          chk("R2 dat_active after cmd", dat_active, 1'b1);
          for (int b = 1; b <= n; b++) begin
            logic same;
            step();
            same = (s == b) && (b % 2 == 1);
            if (s == b && !same) begin stop_req = 1; step(); end
            gap(d[0], n - b + 1, same);
            if (b == n) begin
              chk_all("R3 final gap", 0, 0, 0, 0, 1);
              step();
              chk("R11 done one cycle", xfer_done, 1'b0);
            end else if (s == b) begin
              chk_all(same ? "R7 same-cycle stop" : (d ? "R4 write pause" : "R5 read pause"),
                      0, 0, ~d[0], 1, 0);
              step();
              chk("R11 gap_evt one cycle", gap_evt, 1'b0);
              cont_req = 1; step();
              chk_all("R8 continue", d[0], 1, 0, 0, 0);
            end else begin
              chk_all("R4/R5 plain gap", d[0], 1, 0, 0, 0);
            end
          end
          step();
        end
      end
    end

    // buffer-full read-wait and stop during it
    is_write = 0; cmd_end = 1; step();
    gap(0, 3, 0);
    buf_full = 1; #1;
    chk("R10 read_wait follows buf_full", read_wait, 1'b1);
    step(); step();
    chk_all("R10 no pause without stop", 0, 1, 1, 0, 0);
    stop_req = 1; step();
    chk_all("R6 stop while held", 0, 0, 1, 1, 0);
    buf_full = 0; step();
    chk("R6 read_wait kept after buf_full drops", read_wait, 1'b1);
    cont_req = 1; step();
    chk_all("R8 continue releases read_wait", 0, 1, 0, 0, 0);
    gap(0, 2, 0);
    chk_all("R8 stop cleared by continue", 0, 1, 0, 0, 0);
    cont_req = 1; step();
    chk_all("R9 continue while running ignored", 0, 1, 0, 0, 0);
    is_write = 1; cmd_end = 1; step();
    chk_all("R12 cmd_end while active ignored", 0, 1, 0, 0, 0);
    gap(0, 1, 0);
    chk_all("R3 read completes", 0, 0, 0, 0, 1);
    cont_req = 1; step();
    chk_all("R9 continue while idle ignored", 0, 0, 0, 0, 0);
    stop_req = 1; step();
    is_write = 1; cmd_end = 1; step();
    gap(1, 2, 0);
    chk_all("R9 idle stop dropped", 1, 1, 0, 0, 0);

    // pause a write, then reset mid-pause
    stop_req = 1; step();
    gap(1, 2, 0);
    chk_all("R4 write pause", 0, 0, 0, 1, 0);
    rst = 1; step(); rst = 0;
    chk_all("R1 reset clears", 0, 0, 0, 0, 0);
    cont_req = 1; step();
    chk_all("R1 reset dropped pause", 0, 0, 0, 0, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule